// File: doc/BRIEF.md
# Serial Configuration Readback Streamer

This block reads back the frame-organised configuration and state store of a larger device and sends it out on one serial line. Normal operation is not disturbed. A level on the trigger input starts a pass. The busy flag then rises, and from the next readback clock edge onward one bit leaves on each rising edge. The stream begins with a run of dummy ones. Each frame follows, opened by a low start bit and closed by a group of error-check positions that are always high. The pass ends with one more low start bit and an 11-bit CRC signature. The busy flag drops only after the last CRC bit has been sent.

The block fetches each frame as one word through a synchronous read port with a latency of one cycle. It captures that word and shifts it out most significant bit first. It forces the leading bits of the first frame and the trailing bits of the final frame high. The CRC is accumulated serially over every data bit that was actually sent. Frame length, frame count and the CRC polynomial are parameters.

Top module: `cfg_readback_streamer`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the block returns to idle. After that edge `ser_out` is 1, `busy` is 0 and `rd_en` is 0.
- R2: The block is idle when `busy` is 0. At the first rising edge where the block is idle, armed and samples `trig` high, `busy` goes to 1. `ser_out` stays 1 for that cycle.
- R3: The 1st to 5th edges after the start edge put five 1s on `ser_out`. The 6th edge puts out the low start bit of frame 0.
- R4: Frame f is sent as one 0 start bit followed by the FRAME_LEN bits of word f, most significant bit first. While the start bit of frame f is being sent, `rd_en` is asserted for that one cycle with `rd_addr` = f, and the word is taken from `rd_data` in the next cycle. A pass makes exactly FRAME_CNT reads, at frame indices 0, 1, 2 and so on in order.
- R5: The first two data bits of frame 0 are sent as 1, whatever the stored word holds.
- R6: Every frame's data is followed by four 1s, the error-check positions.
- R7: The last seven data bits of the final frame (frame FRAME_CNT-1) are sent as 1, whatever the stored word holds.
- R8: After the final frame's check bits, one 0 is sent and then 11 CRC bits, most significant first. The CRC starts at zero for each pass. It is updated once for each sent data bit b, forced bits included; start and check bits do not count. The update is fb = b ^ crc[10], crc = {crc[9:0],0} ^ (fb ? CRC_POLY : 0).
- R9: At the edge after the last CRC bit has been shown, `busy` returns to 0 and `ser_out` to 1. `ser_out` is 1 whenever `busy` is 0.
- R10: `trig` has no effect while a pass runs. A pass starts only when `trig` has been sampled low at some edge after the previous start. A trigger held high across the end of a pass starts no new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Level-sensitive readback request |
| ser_out | output | 1 | Serial readback data |
| busy | output | 1 | Read in progress |
| rd_en | output | 1 | Frame-word read strobe |
| rd_addr | output | ADDR_W | Frame index of the read |
| rd_data | input | FRAME_LEN | Frame word, valid the cycle after `rd_en` |

## Verification
The bench goes after the off-by-one risks in the framing. If the fetch were issued one cycle late, the first data bit of every frame would come from the previous word. If the forcing windows were mis-sized, all-zero and all-one memories would expose it at the frame 0 head and the final frame tail. If the CRC covered start or check bits, or were sent least significant bit first, the signature would differ from the bench's serial model. The end of a pass is checked on its exact edge. The trigger is held high through the end of a pass and also toggled mid-pass, which catches a design that restarts or stutters on the level.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    localparam int DUMMY_BITS = 5;
    localparam int CHECK_BITS = 4;
    localparam int CRC_W      = 11;
    localparam int HEAD_FORCE = 2;
    localparam int TAIL_FORCE = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DUMMY,
        PH_START,
        PH_DATA,
        PH_CHECK,
        PH_CLOSE,
        PH_CRC,
        PH_FINISH
    } rbk_phase_e;

    typedef struct packed {
        logic clear;
        logic update;
        logic shift;
    } crc_ctl_t;

    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             din,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = din ^ cur[CRC_W-1];
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/rbk_sequencer.sv
module rbk_sequencer
    import rbk_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int FRAME_CNT = 4,
    parameter int CNT_W     = 4,
    parameter int FR_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    output rbk_phase_e       phase,
    output logic             busy,
    output logic             rd_en,
    output logic [FR_W-1:0]  rd_addr,
    output logic             force_hi,
    output logic             word_first,
    output crc_ctl_t         crc_ctl
);

    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_CHECK = CNT_W'(CHECK_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CRC   = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] HEAD_END   = CNT_W'(HEAD_FORCE);
    localparam logic [CNT_W-1:0] TAIL_FROM  = CNT_W'(FRAME_LEN - TAIL_FORCE);
    localparam logic [FR_W-1:0]  LAST_FRAME = FR_W'(FRAME_CNT - 1);

    logic [CNT_W-1:0] cnt;
    logic [FR_W-1:0]  frame;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            frame <= '0;
            busy  <= 1'b0;
            armed <= 1'b1;
        end else begin
            if (!trig) begin
                armed <= 1'b1;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (trig && armed) begin
                        phase <= PH_DUMMY;
                        cnt   <= '0;
                        frame <= '0;
                        busy  <= 1'b1;
                        armed <= 1'b0;
                    end
                end
                PH_DUMMY: begin
                    if (cnt == LAST_DUMMY) begin
                        phase <= PH_START;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_START: begin
                    phase <= PH_DATA;
                    cnt   <= '0;
                end
                PH_DATA: begin
                    if (cnt == LAST_DATA) begin
                        phase <= PH_CHECK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CHECK: begin
                    if (cnt == LAST_CHECK) begin
                        cnt <= '0;
                        if (frame == LAST_FRAME) begin
                            phase <= PH_CLOSE;
                        end else begin
                            phase <= PH_START;
                            frame <= frame + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CLOSE: begin
                    phase <= PH_CRC;
                    cnt   <= '0;
                end
                PH_CRC: begin
                    if (cnt == LAST_CRC) begin
                        phase <= PH_FINISH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_FINISH: begin
                    phase <= PH_IDLE;
                    busy  <= 1'b0;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    logic in_data;
    logic head_zone;
    logic tail_zone;

    always_comb begin
        in_data    = (phase == PH_DATA);
        head_zone  = (frame == '0) && (cnt < HEAD_END);
        tail_zone  = (frame == LAST_FRAME) && (cnt >= TAIL_FROM);
        force_hi   = in_data && (head_zone || tail_zone);
        word_first = in_data && (cnt == '0);
        rd_en      = (phase == PH_START);
        rd_addr    = frame;
        crc_ctl.clear  = (phase == PH_IDLE);
        crc_ctl.update = in_data;
        crc_ctl.shift  = (phase == PH_CRC);
    end

endmodule

// File: rtl/rbk_frame_shifter.sv
module rbk_frame_shifter #(
    parameter int FRAME_LEN = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_first,
    input  logic                 advance,
    input  logic                 force_hi,
    input  logic [FRAME_LEN-1:0] rd_data,
    output logic                 data_bit
);

    logic [FRAME_LEN-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (word_first) begin
            hold <= rd_data << 1;
        end else if (advance) begin
            hold <= hold << 1;
        end
    end

    always_comb begin
        if (word_first) begin
            data_bit = rd_data[FRAME_LEN-1] | force_hi;
        end else begin
            data_bit = hold[FRAME_LEN-1] | force_hi;
        end
    end

endmodule

// File: rtl/rbk_crc11.sv
module rbk_crc11
    import rbk_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 11'h385
) (
    input  logic     clk,
    input  logic     rst,
    input  crc_ctl_t ctl,
    input  logic     din,
    output logic     msb
);

    logic [CRC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            acc <= '0;
        end else if (ctl.update) begin
            acc <= crc_step(acc, din, CRC_POLY);
        end else if (ctl.shift) begin
            acc <= {acc[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = acc[CRC_W-1];

endmodule

// File: rtl/cfg_readback_streamer.sv
module cfg_readback_streamer
    import rbk_pkg::*;
#(
    parameter int               FRAME_LEN = 16,
    parameter int               FRAME_CNT = 4,
    parameter logic [CRC_W-1:0] CRC_POLY  = 11'h385,
    localparam int              ADDR_W    = (FRAME_CNT > 1) ? $clog2(FRAME_CNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig,
    output logic                 ser_out,
    output logic                 busy,
    output logic                 rd_en,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [FRAME_LEN-1:0] rd_data
);

    localparam int MAX_CNT = (FRAME_LEN > CRC_W) ? FRAME_LEN : CRC_W;
    localparam int CNT_W   = $clog2(MAX_CNT);

    rbk_phase_e seq_phase;
    logic       force_hi;
    logic       word_first;
    crc_ctl_t   crc_ctl;
    logic       data_bit;
    logic       crc_msb;

    rbk_sequencer #(
        .FRAME_LEN (FRAME_LEN),
        .FRAME_CNT (FRAME_CNT),
        .CNT_W     (CNT_W),
        .FR_W      (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .phase      (seq_phase),
        .busy       (busy),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .force_hi   (force_hi),
        .word_first (word_first),
        .crc_ctl    (crc_ctl)
    );

    rbk_frame_shifter #(
        .FRAME_LEN (FRAME_LEN)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .word_first (word_first),
        .advance    (crc_ctl.update),
        .force_hi   (force_hi),
        .rd_data    (rd_data),
        .data_bit   (data_bit)
    );

    rbk_crc11 #(
        .CRC_POLY (CRC_POLY)
    ) u_crc (
        .clk (clk),
        .rst (rst),
        .ctl (crc_ctl),
        .din (data_bit),
        .msb (crc_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out <= 1'b1;
        end else begin
            unique case (seq_phase)
                PH_START, PH_CLOSE: ser_out <= 1'b0;
                PH_DATA:            ser_out <= data_bit;
                PH_CRC:             ser_out <= crc_msb;
                default:            ser_out <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/cfg_readback_streamer_chk.sv
module cfg_readback_streamer_chk
    import rbk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       trig,
    input logic       busy,
    input logic       ser_out,
    input logic       rd_en,
    input rbk_phase_e phase
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ser_out && !busy && !rd_en));

    a_r2_start_needs_trig: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig));

    a_r2_start_line_high: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ser_out);

    a_r3_dummy_high: assert property (@(posedge clk) disable iff (rst)
        $past(phase == PH_DUMMY) |-> ser_out);

    a_r4_start_bit_low: assert property (@(posedge clk) disable iff (rst)
        $past(phase == PH_START) |-> !ser_out);

    a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    a_r4_read_in_pass: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    a_r6_check_high: assert property (@(posedge clk) disable iff (rst)
        $past(phase == PH_CHECK) |-> ser_out);

    a_r8_close_low: assert property (@(posedge clk) disable iff (rst)
        $past(phase == PH_CLOSE) |-> !ser_out);

    a_r9_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ser_out);

endmodule

bind cfg_readback_streamer cfg_readback_streamer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .trig    (trig),
    .busy    (busy),
    .ser_out (ser_out),
    .rd_en   (rd_en),
    .phase   (seq_phase)
);

// File: tb/cfg_readback_streamer_tb.sv
module cfg_readback_streamer_tb;

    localparam int          L      = 16;
    localparam int          F      = 4;
    localparam logic [10:0] POLY   = 11'h385;
    localparam int          AW     = $clog2(F);
    localparam int          NBITS  = 5 + F * (L + 5) + 1 + 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic          ser_out;
    logic          busy;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [L-1:0]  rd_data = '0;

    logic [L-1:0]  mem [F];
    int            checks = 0;
    int            errors = 0;
    int            reads = 0;
    int            addr_errs = 0;
    int            next_addr = 0;

    logic          exp_bit [1:NBITS];
    int            exp_tag [1:NBITS];

    always #2 clk = ~clk;

    cfg_readback_streamer #(
        .FRAME_LEN (L),
        .FRAME_CNT (F),
        .CRC_POLY  (POLY)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .ser_out (ser_out),
        .busy    (busy),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            if (int'(rd_addr) != next_addr) addr_errs++;
            next_addr++;
            reads++;
        end
    end

    function automatic string tag_name(input int t);
        case (t)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build_expected();
        logic [10:0] c = '0;
        int          k = 1;
        logic        b;
        logic        fb;
        for (int i = 0; i < 5; i++) begin
            exp_bit[k] = 1'b1; exp_tag[k] = 3; k++;
        end
        for (int f = 0; f < F; f++) begin
            exp_bit[k] = 1'b0; exp_tag[k] = (f == 0) ? 3 : 4; k++;
            for (int i = 0; i < L; i++) begin
                b = mem[f][L-1-i];
                exp_tag[k] = 4;
                if (f == 0 && i < 2) begin
                    b = 1'b1; exp_tag[k] = 5;
                end
                if (f == F - 1 && i >= L - 7) begin
                    b = 1'b1; exp_tag[k] = 7;
                end
                fb = b ^ c[10];
                c  = {c[9:0], 1'b0} ^ (fb ? POLY : 11'h000);
                exp_bit[k] = b; k++;
            end
            for (int i = 0; i < 4; i++) begin
                exp_bit[k] = 1'b1; exp_tag[k] = 6; k++;
            end
        end
        exp_bit[k] = 1'b0; exp_tag[k] = 8; k++;
        for (int i = 10; i >= 0; i--) begin
            exp_bit[k] = c[i]; exp_tag[k] = 8; k++;
        end
    endtask

    // mode 0: trig dropped at end; 1: held high past end; 2: toggled mid-pass
    task automatic run_pass(input int mode);
        build_expected();
        reads = 0;
        next_addr = 0;
        addr_errs = 0;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2", int'(busy), 1);
        chk(ser_out == 1'b1, "R2", int'(ser_out), 1);
        for (int k = 1; k <= NBITS; k++) begin
            if (mode == 2 && k == 20) trig = 1'b0;
            if (mode == 2 && k == 23) trig = 1'b1;
            if (mode == 2 && k == 40) trig = 1'b0;
            @(negedge clk);
            chk(ser_out == exp_bit[k], tag_name(exp_tag[k]), int'(ser_out), int'(exp_bit[k]));
            chk(busy == 1'b1, "R9", int'(busy), 1);
        end
        @(negedge clk);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        chk(ser_out == 1'b1, "R9", int'(ser_out), 1);
        chk(reads == F, "R4", reads, F);
        chk(addr_errs == 0, "R4", addr_errs, 0);
        if (mode != 1) trig = 1'b0;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(ser_out == 1'b1, "R1", int'(ser_out), 1);
        chk(busy == 1'b0, "R1", int'(busy), 0);
        chk(rd_en == 1'b0, "R1", int'(rd_en), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", int'(busy), 0);
    endtask

    task automatic t_zeros();
        for (int f = 0; f < F; f++) mem[f] = '0;
        run_pass(0);
    endtask

    task automatic t_ones();
        for (int f = 0; f < F; f++) mem[f] = '1;
        run_pass(0);
    endtask

    task automatic t_mixed();
        for (int f = 0; f < F; f++) mem[f] = L'(16'hA5C3 ^ (f * 16'h1357));
        run_pass(0);
    endtask

    task automatic t_held_trigger();
        for (int f = 0; f < F; f++) mem[f] = L'(16'h6E21 + f * 16'h0F0F);
        run_pass(1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R10", int'(busy), 0);
            chk(ser_out == 1'b1, "R10", int'(ser_out), 1);
        end
        trig = 1'b0;
        @(negedge clk);
        run_pass(0);
    endtask

    task automatic t_toggle_mid_pass();
        for (int f = 0; f < F; f++) mem[f] = L'(16'h3C5A - f * 16'h0123);
        run_pass(2);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R10", int'(busy), 0);
        end
    endtask

    task automatic t_reset_mid_pass();
        for (int f = 0; f < F; f++) mem[f] = '0;
        @(negedge clk);
        trig = 1'b1;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        trig = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", int'(busy), 0);
        chk(ser_out == 1'b1, "R1", int'(ser_out), 1);
        rst = 1'b0;
        @(negedge clk);
        run_pass(0);
    endtask

    initial begin
        for (int f = 0; f < F; f++) mem[f] = '0;
        t_reset();
        t_zeros();
        t_ones();
        t_mixed();
        t_held_trigger();
        t_toggle_mid_pass();
        t_reset_mid_pass();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule